// File: doc/BRIEF.md
# IrDA SIR Infrared Pulse Codec

This block sits between a UART and an infrared transceiver. On the transmit side it watches the UART output line. Every serial zero becomes one short high pulse on the infrared drive line. A serial one leaves the line dark. On the receive side it watches the detector output. Each incoming pulse edge becomes a low level on the recovered serial line, and that level lasts one full bit time, so the UART sees an ordinary NRZ stream.

Bit cells are tracked with the same 16x baud tick that the UART uses. Any change of the transmit line that is seen on a tick restarts the tick position inside the cell. Runs of equal bits wrap the position every 16 ticks. Pulses always begin at the 8th tick of a zero cell.

The pulse width comes from one of two sources, picked by a mode input:

- **Bit-relative mode:** the width is three baud ticks, so it scales with the bit rate.
- **Fixed-width mode:** the width is three periods of a reference rate. That rate is made by dividing the oscillator clock by a 5-bit divisor, so the width is fixed in absolute time.

The divisor register starts at 15 after reset. It follows the divisor input only while no pulse is being sent. For the reference rate, aim for about 1.83 MHz, which gives roughly 1.63 µs pulses. The usable range is 1.34 to 2.13 MHz. Suitable divisors are:

| Oscillator | Divisor |
|---|---|
| 40 MHz | 22 |
| 36.864 MHz | 20 |
| 24 MHz | 13 |
| 11.059 MHz | 6 |
| 7.3728 MHz | 4 |

Top module: `irda_sir_codec`

## Requirements
- R1: While reset is asserted, and right after it is released, `irTx` is 0 and `rxData` is 1.
- R2: A bit cell in which `txData` is 1 produces no high sample on `irTx`.
- R3: In a zero cell, `irTx` goes high on the clock edge of the 8th baud tick of the cell. The tick on which the transition of `txData` was seen counts as the 1st tick. A zero cell produces exactly one pulse.
- R4: With `pulseMode` = 1, a pulse stays high for exactly 3 baud-tick periods. With a regular tick every TP clocks, that is 3·TP clock cycles.
- R5: With `pulseMode` = 0 and divisor D ≥ 4, a pulse stays high for exactly 3·D clock cycles.
- R6: With `pulseMode` = 0, a divisor below 4 (including 0) acts as 4, which gives a 12-cycle pulse.
- R7: A change of `clkDiv` while a pulse is high does not alter that pulse. The next pulse uses the new value.
- R8: A rising edge on `irRx` makes `rxData` go low on the third clock edge after the edge is sampled (two synchronizer stages, then the edge detector). `rxData` returns high on the clock edge of the 16th baud tick after the low began.
- R9: Further `irRx` edges while `rxData` is low are ignored. The low period is not extended.
- R10: `irRx` activity while `irTx` is high, or within 3 clock cycles after it falls, never pulls `rxData` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; all logic is clocked on its rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| baudTick | input | 1 | One-cycle strobe at 16 times the bit rate |
| txData | input | 1 | Serial transmit line from the UART, idle high |
| clkDiv | input | 5 | Divisor for the reference rate used in fixed-width mode |
| pulseMode | input | 1 | 0 = fixed-width pulses, 1 = pulses of 3/16 bit |
| irRx | input | 1 | Detector output, high while light is received |
| irTx | output | 1 | Infrared drive line, high during a pulse |
| rxData | output | 1 | Recovered serial receive line, idle high |

## Verification
The assertions check some rules on every cycle:

- Pulse edges are tied to baud ticks and to a low transmit line.
- In fixed-width mode, every pulse length is a multiple of three and at least twelve cycles.
- Receive lows begin only three cycles after `irRx` rose, and end only on a tick.
- A receive low never begins while a pulse is being sent.

Some behaviour depends on the stimulus as a whole, so only the bench scenarios can show it:

- The exact start position inside a cell.
- The exact widths for a given divisor or tick period.
- The clamping of small divisors.
- The latching of the divisor during a pulse.
- The refusal to retrigger the receive low.
- Echo suppression with a looped-back transceiver.

// File: rtl/irda_sir_pkg.sv
package irda_sir_pkg;

  // Strobes from control to datapath, valid for one clock
  typedef struct packed {
    logic startTx;    // begin an infrared pulse now
    logic pulseUnit;  // one width unit elapsed (tick or reference period)
    logic armRx;      // accepted receive edge, open a low bit window
    logic tick;       // baud tick forwarded for the receive window
  } ctlStrobe_t;

  // State reported by datapath to control
  typedef struct packed {
    logic txActive;   // pulse currently driven
    logic echoBlank;  // receive edges must be ignored
    logic rxSynced;   // synchronized detector level
    logic rxBusy;     // receive low window open
    logic refEn;      // reference period boundary during a pulse
  } dpStatus_t;

endpackage

// File: rtl/irda_sir_prescaler.sv
module irda_sir_prescaler #(
  parameter int DIV_W     = 5,
  parameter int DIV_RESET = 15,
  parameter int DIV_MIN   = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] clkDiv,
  input  logic             fixedMode,
  input  logic             loadEn,
  input  logic             restart,
  input  logic             run,
  output logic             refEn
);

  localparam logic [DIV_W-1:0] RESET_DIV = DIV_W'(DIV_RESET);
  localparam logic [DIV_W-1:0] MIN_DIV   = DIV_W'(DIV_MIN);
  localparam logic [DIV_W-1:0] ONE       = DIV_W'(1);

  logic [DIV_W-1:0] divReg;
  logic [DIV_W-1:0] effDiv;
  logic [DIV_W-1:0] lastCnt;
  logic [DIV_W-1:0] divCnt;

  // Divisor is frozen while a pulse runs so its width stays intact
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       divReg <= RESET_DIV;
    else if (loadEn) divReg <= clkDiv;
  end

  always_comb begin
    effDiv = divReg;
    if (fixedMode && divReg < MIN_DIV) effDiv = MIN_DIV;
    else if (divReg == '0)             effDiv = ONE;
    lastCnt = effDiv - ONE;
  end

  // Phase restarts at pulse start, giving whole reference periods
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  divCnt <= '0;
    else if (restart)           divCnt <= '0;
    else if (run) begin
      if (divCnt == lastCnt)    divCnt <= '0;
      else                      divCnt <= divCnt + ONE;
    end
  end

  assign refEn = run && (divCnt == lastCnt);

endmodule

// File: rtl/irda_sir_datapath.sv
module irda_sir_datapath
  import irda_sir_pkg::*;
#(
  parameter int DIV_W         = 5,
  parameter int DIV_RESET     = 15,
  parameter int DIV_MIN       = 4,
  parameter int PULSE_UNITS   = 3,
  parameter int TICKS_PER_BIT = 16,
  parameter int SYNC_STAGES   = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] clkDiv,
  input  logic             pulseMode,
  input  logic             irRx,
  input  ctlStrobe_t       ctl,
  output dpStatus_t        sts,
  output logic             irTx,
  output logic             rxData
);

  localparam int UNIT_W  = $clog2(PULSE_UNITS + 1);
  localparam int RX_W    = $clog2(TICKS_PER_BIT + 1);
  localparam int GUARD   = SYNC_STAGES + 1;
  localparam int GUARD_W = $clog2(GUARD + 1);
  localparam logic [UNIT_W-1:0]  UNITS_LOAD = UNIT_W'(PULSE_UNITS);
  localparam logic [UNIT_W-1:0]  UNIT_ONE   = UNIT_W'(1);
  localparam logic [RX_W-1:0]    RX_LOAD    = RX_W'(TICKS_PER_BIT);
  localparam logic [RX_W-1:0]    RX_ONE     = RX_W'(1);
  localparam logic [GUARD_W-1:0] GUARD_LOAD = GUARD_W'(GUARD);
  localparam logic [GUARD_W-1:0] GUARD_ONE  = GUARD_W'(1);

  logic                txActive;
  logic [UNIT_W-1:0]   unitCnt;
  logic [GUARD_W-1:0]  guardCnt;
  logic [RX_W-1:0]     rxCnt;
  logic                rxBusy;
  logic                refEn;
  logic [SYNC_STAGES-1:0] syncReg;

  irda_sir_prescaler #(
    .DIV_W    (DIV_W),
    .DIV_RESET(DIV_RESET),
    .DIV_MIN  (DIV_MIN)
  ) uPrescaler (
    .clk      (clk),
    .rstN     (rstN),
    .clkDiv   (clkDiv),
    .fixedMode(!pulseMode),
    .loadEn   (!txActive),
    .restart  (ctl.startTx),
    .run      (txActive),
    .refEn    (refEn)
  );

  // Transmit pulse: loaded with the unit count, ends on the last unit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txActive <= 1'b0;
      unitCnt  <= '0;
    end else if (ctl.startTx && !txActive) begin
      txActive <= 1'b1;
      unitCnt  <= UNITS_LOAD;
    end else if (txActive && ctl.pulseUnit) begin
      if (unitCnt == UNIT_ONE) txActive <= 1'b0;
      unitCnt <= unitCnt - UNIT_ONE;
    end
  end

  // Echo guard covers the synchronizer latency after a pulse ends
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                guardCnt <= '0;
    else if (txActive)        guardCnt <= GUARD_LOAD;
    else if (guardCnt != '0)  guardCnt <= guardCnt - GUARD_ONE;
  end

  // Detector synchronizer
  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : gSync
      if (g == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncReg[0] <= 1'b0;
          else       syncReg[0] <= irRx;
        end
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncReg[g] <= 1'b0;
          else       syncReg[g] <= syncReg[g-1];
        end
      end
    end
  endgenerate

  // Receive low window of one bit time
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxBusy <= 1'b0;
      rxCnt  <= '0;
    end else if (ctl.armRx) begin
      rxBusy <= 1'b1;
      rxCnt  <= RX_LOAD;
    end else if (rxBusy && ctl.tick) begin
      if (rxCnt == RX_ONE) rxBusy <= 1'b0;
      rxCnt <= rxCnt - RX_ONE;
    end
  end

  always_comb begin
    sts.txActive  = txActive;
    sts.echoBlank = txActive || (guardCnt != '0);
    sts.rxSynced  = syncReg[SYNC_STAGES-1];
    sts.rxBusy    = rxBusy;
    sts.refEn     = refEn;
  end

  assign irTx   = txActive;
  assign rxData = !rxBusy;

endmodule

// File: rtl/irda_sir_ctrl.sv
module irda_sir_ctrl
  import irda_sir_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int PULSE_TICK    = 7
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       baudTick,
  input  logic       txData,
  input  logic       pulseMode,
  input  dpStatus_t  sts,
  output ctlStrobe_t ctl
);

  localparam int POS_W = (TICKS_PER_BIT > 2) ? $clog2(TICKS_PER_BIT) : 1;
  localparam logic [POS_W-1:0] LAST_POS  = POS_W'(TICKS_PER_BIT - 1);
  localparam logic [POS_W-1:0] START_POS = POS_W'(PULSE_TICK);
  localparam logic [POS_W-1:0] POS_ONE   = POS_W'(1);

  logic             txPrev;
  logic [POS_W-1:0] cellPos;
  logic [POS_W-1:0] nextPos;
  logic             rxPrev;

  // A line change seen on a tick marks the first tick of a cell
  always_comb begin
    if (txData != txPrev)       nextPos = '0;
    else if (cellPos == LAST_POS) nextPos = '0;
    else                        nextPos = cellPos + POS_ONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txPrev  <= 1'b1;
      cellPos <= '0;
    end else if (baudTick) begin
      txPrev  <= txData;
      cellPos <= nextPos;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxPrev <= 1'b0;
    else       rxPrev <= sts.rxSynced;
  end

  always_comb begin
    ctl.startTx   = baudTick && !txData && (nextPos == START_POS) && !sts.txActive;
    ctl.pulseUnit = pulseMode ? baudTick : sts.refEn;
    ctl.armRx     = sts.rxSynced && !rxPrev && !sts.echoBlank && !sts.rxBusy;
    ctl.tick      = baudTick;
  end

endmodule

// File: rtl/irda_sir_codec.sv
module irda_sir_codec
  import irda_sir_pkg::*;
#(
  parameter int DIV_W         = 5,
  parameter int DIV_RESET     = 15,
  parameter int DIV_MIN       = 4,
  parameter int PULSE_UNITS   = 3,
  parameter int TICKS_PER_BIT = 16,
  parameter int PULSE_TICK    = 7,
  parameter int SYNC_STAGES   = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             baudTick,
  input  logic             txData,
  input  logic [DIV_W-1:0] clkDiv,
  input  logic             pulseMode,
  input  logic             irRx,
  output logic             irTx,
  output logic             rxData
);

  ctlStrobe_t ctl;
  dpStatus_t  sts;

  irda_sir_ctrl #(
    .TICKS_PER_BIT(TICKS_PER_BIT),
    .PULSE_TICK   (PULSE_TICK)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .baudTick (baudTick),
    .txData   (txData),
    .pulseMode(pulseMode),
    .sts      (sts),
    .ctl      (ctl)
  );

  irda_sir_datapath #(
    .DIV_W        (DIV_W),
    .DIV_RESET    (DIV_RESET),
    .DIV_MIN      (DIV_MIN),
    .PULSE_UNITS  (PULSE_UNITS),
    .TICKS_PER_BIT(TICKS_PER_BIT),
    .SYNC_STAGES  (SYNC_STAGES)
  ) uDatapath (
    .clk      (clk),
    .rstN     (rstN),
    .clkDiv   (clkDiv),
    .pulseMode(pulseMode),
    .irRx     (irRx),
    .ctl      (ctl),
    .sts      (sts),
    .irTx     (irTx),
    .rxData   (rxData)
  );

endmodule

// File: rtl/irda_sir_codec_chk.sv
module irda_sir_codec_chk (
  input logic clk,
  input logic rstN,
  input logic baudTick,
  input logic txData,
  input logic pulseMode,
  input logic irRx,
  input logic irTx,
  input logic rxData
);

  logic [15:0] hiLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     hiLen <= '0;
    else if (irTx) hiLen <= hiLen + 16'd1;
    else           hiLen <= '0;
  end

  // R1
  always @(posedge clk) begin
    if (!rstN) begin
      reset_state_chk: assert (irTx == 1'b0 && rxData == 1'b1);
    end
  end

  // R3
  tx_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irTx) |-> $past(baudTick && !txData));

  // R4
  tx_bit_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(irTx) && pulseMode) |-> $past(baudTick));

  // R5 R6
  tx_fixed_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(irTx) && !pulseMode) |-> (hiLen >= 16'd12 && (hiLen % 16'd3) == 16'd0));

  // R8
  rx_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rxData) |-> $past(irRx, 3));

  // R8
  rx_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxData) |-> $past(baudTick));

  // R10
  echo_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rxData) |-> !$past(irTx));

endmodule

bind irda_sir_codec irda_sir_codec_chk uChk (
  .clk      (clk),
  .rstN     (rstN),
  .baudTick (baudTick),
  .txData   (txData),
  .pulseMode(pulseMode),
  .irRx     (irRx),
  .irTx     (irTx),
  .rxData   (rxData)
);

// File: tb/tb_irda_sir_codec.sv
module tb_irda_sir_codec;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic       clk;
  logic       rstN;
  logic       baudTick;
  logic       txData;
  logic [4:0] clkDiv;
  logic       pulseMode;
  logic       irRxDrv;
  logic       loopBack;
  wire        irRx;
  wire        irTx;
  wire        rxData;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  assign irRx = loopBack ? irTx : irRxDrv;

  irda_sir_codec dut (
    .clk      (clk),
    .rstN     (rstN),
    .baudTick (baudTick),
    .txData   (txData),
    .clkDiv   (clkDiv),
    .pulseMode(pulseMode),
    .irRx     (irRx),
    .irTx     (irTx),
    .rxData   (rxData)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Inputs apply to the next rising edge; returns at the following falling edge
  task automatic step(input logic tk);
    baudTick = tk;
    @(negedge clk);
  endtask

  function automatic int expWidth(input bit mode, input int div, input int tp);
    if (mode) return 3 * tp;
    return 3 * ((div < 4) ? 4 : div);
  endfunction

  task automatic sendCell(input bit b, input int tp, input int expW, input int newDiv);
    int hi = 0;
    int first = -1;
    int rxBad = 0;
    txData = b;
    for (int s = 0; s < 16 * tp; s++) begin
      if (newDiv >= 0 && s == 7 * tp + 1) clkDiv = 5'(newDiv);
      step((s % tp) == 0);
      if (irTx) begin
        if (first < 0) first = s;
        hi++;
      end
      if (loopBack && !rxData) rxBad++;
    end
    if (b) begin
      check(hi == 0, "R2 one cell dark", hi, 0);
    end else begin
      check(hi == expW, pulseMode ? "R4 bit width" : "R5/R6/R7 fixed width", hi, expW);
      check(first == 7 * tp, "R3 pulse start", first, 7 * tp);
    end
    if (loopBack) check(rxBad == 0, "R10 echo blocked", rxBad, 0);
  endtask

  task automatic sendFrame(input logic [7:0] data, input bit mode, input int div, input int tp);
    int w;
    pulseMode = mode;
    clkDiv    = 5'(div);
    w = expWidth(mode, div, tp);
    sendCell(1'b0, tp, w, -1);
    for (int i = 0; i < 8; i++) sendCell(data[i], tp, w, -1);
    sendCell(1'b1, tp, w, -1);
    sendCell(1'b1, tp, w, -1);
  endtask

  // Receive pulse at step m, optional second pulse at m+secondOff
  task automatic rxTest(input int tp, input int phase, input int secondOff, input string req);
    int m = 5;
    int k = -1;
    int tcnt = 0;
    int bad = 0;
    int lowCnt = 0;
    int s = 0;
    bit expLow;
    bit tk;
    loopBack = 1'b0;
    txData   = 1'b1;
    irRxDrv  = 1'b0;
    while (k < 0 || s < k + 6) begin
      if (s == m || (secondOff > 0 && s == m + secondOff)) irRxDrv = 1'b1;
      if (s == m + 3 || (secondOff > 0 && s == m + secondOff + 2)) irRxDrv = 1'b0;
      tk = ((s + phase) % tp) == 0;
      step(tk);
      if (tk && s > m + 2) begin
        tcnt++;
        if (tcnt == 16) k = s;
      end
      expLow = (s >= m + 2) && (k < 0 || s < k);
      if (!rxData) lowCnt++;
      if (rxData != !expLow) bad++;
      s++;
      if (s > 4000) break;
    end
    check(bad == 0, req, bad, 0);
    check(lowCnt == k - (m + 2), req, lowCnt, k - (m + 2));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rstN      = 1'b0;
    baudTick  = 1'b0;
    txData    = 1'b1;
    clkDiv    = 5'd15;
    pulseMode = 1'b0;
    irRxDrv   = 1'b0;
    loopBack  = 1'b0;
    repeat (3) @(negedge clk);
    check(irTx == 1'b0, "R1 irTx in reset", int'(irTx), 0);
    check(rxData == 1'b1, "R1 rxData in reset", int'(rxData), 1);
    rstN = 1'b1;
    step(1'b0);
    check(irTx == 1'b0, "R1 irTx after reset", int'(irTx), 0);
    check(rxData == 1'b1, "R1 rxData after reset", int'(rxData), 1);

    // R4 bit-relative widths at extreme tick spacings
    sendFrame(8'h00, 1'b1, 0, 1);
    sendFrame(8'hA5, 1'b1, 9, 4);
    // R5 fixed widths
    sendFrame(8'h3C, 1'b0, 20, 11);
    sendFrame(8'h81, 1'b0, 31, 11);
    // R6 clamping of small divisors
    sendFrame(8'h5A, 1'b0, 3, 11);
    sendFrame(8'hF0, 1'b0, 0, 11);
    // R2 all ones
    sendFrame(8'hFF, 1'b0, 4, 11);

    // R7 divisor change during a pulse
    pulseMode = 1'b0;
    clkDiv    = 5'd20;
    sendCell(1'b0, 11, 60, 5);
    sendCell(1'b0, 11, 15, -1);
    sendCell(1'b1, 11, 0, -1);

    // R8 receive window at several tick spacings and phases
    rxTest(1, 0, 0, "R8 rx window tp1");
    rxTest(3, 1, 0, "R8 rx window tp3");
    rxTest(7, 4, 0, "R8 rx window tp7");
    // R9 second edge inside the low window
    rxTest(4, 2, 30, "R9 no retrigger");
    rxTest(5, 0, 50, "R9 no retrigger late");

    // R10 looped-back echo in both modes
    loopBack = 1'b1;
    sendFrame(8'h00, 1'b1, 0, 1);
    sendFrame(8'h66, 1'b0, 2, 12);
    loopBack = 1'b0;

    // Constrained random frames
    for (int i = 0; i < 10; i++) begin
      bit mode;
      int tp;
      int div;
      mode     = 1'($urandom % 2);
      tp       = mode ? (1 + int'($urandom % 4)) : (11 + int'($urandom % 3));
      div      = int'($urandom % 32);
      loopBack = 1'($urandom % 2);
      sendFrame(8'($urandom), mode, div, tp);
    end
    loopBack = 1'b0;

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule